// File: doc/BRIEF.md
# Frame Timing Generator with Sync

This block is the master timing counter of a time-division bus interface. It runs on the 16.384 MHz master clock and counts one 8 kHz frame of 2048 master cycles. From that single counter it derives one-cycle clock enables at 8.192 MHz, 4.096 MHz and 2.048 MHz and an active-low frame strobe that straddles the frame boundary. When the master input is slower than 16.384 MHz, a rate code and an input tick let the counter advance by 2 or 4 per tick, so that frame position is always counted in 16.384 MHz units.

A mode input selects between free running and synchronising. In sync mode a select input picks either the backplane frame signal or an external 8 kHz reference. A falling edge on the picked source passes a two-stage synchroniser and then re-phases the counter to a fixed alignment value. A one-cycle slip pulse reports a re-phase that moved the counter by more than one count, and a loss-of-sync flag reports two frames without any edge.

Sync tracking is a four-state machine. FREE: the mode input is low, so edges are ignored and loss-of-sync is low. Any state goes to FREE when the mode input drops. FREE goes to LOCKED if an edge arrives in the first sync-mode cycle, and otherwise to HUNT. HUNT goes to LOCKED on an edge. HUNT goes to LOST on the second counter wrap without an edge. LOCKED stays LOCKED on each edge and goes to LOST on the second wrap without an edge. LOST goes to LOCKED on an edge.

Top module: `frame_timebase`

## Requirements
- R1: While reset is held and right after it, frame_pos is 0, frame_n is 0, and en_8m, en_4m, en_2m, slip and los are 0.
- R2: Each cycle with in_tick high, frame_pos advances by 1, 2 or 4 for in_rate code 0, 1 or 2. Code 3 behaves as code 0. The count wraps from 2047 to 0.
- R3: After each update of frame_pos, en_8m, en_4m and en_2m are high for exactly that cycle when the new value is a multiple of 2, 4 or 8. With rate code 0 this gives 1024, 512 and 256 pulses per frame.
- R4: frame_n is low exactly while frame_pos is in {2046, 2047, 0, 1}. At every rate code this keeps it low for 4 master cycles per 2048-cycle frame.
- R5: With sync_mode = 0, falling edges on bp_frame_n and ext_ref do not change frame_pos, and los stays 0.
- R6: With sync_mode = 1, a falling edge on the selected source is applied SYNC_STAGES + 1 = 3 cycles after the input changes. frame_pos is then set to the alignment value 3, and this takes priority over any advance.
- R7: sync_sel = 0 selects bp_frame_n and sync_sel = 1 selects ext_ref. Edges on the unselected source have no effect.
- R8: slip is high for the single cycle in which a re-phased value is shown, but only if that value differs from the advanced value by 2 or more counts (modulo 2048). A difference of 0 or ±1 gives no slip.
- R9: In sync mode, los rises in the cycle frame_pos wraps to 0 for the second time without a sync edge. The next applied edge clears it.
- R10: A re-phase is never counted as a wrap. If an edge is applied in the cycle that would have been the second wrap, los stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_tick | input | 1 | Master-input enable; advances the counter |
| in_rate | input | 2 | Master-input rate: 0 = 16.384, 1 = 8.192, 2 = 4.096 MHz |
| sync_mode | input | 1 | 0 = free run, 1 = synchronise |
| sync_sel | input | 1 | 0 = backplane frame, 1 = external 8 kHz reference |
| bp_frame_n | input | 1 | Backplane frame signal, active low |
| ext_ref | input | 1 | External 8 kHz reference, falling edge used |
| frame_pos | output | 11 | Position within the frame in master counts |
| en_8m | output | 1 | 8.192 MHz clock enable pulse |
| en_4m | output | 1 | 4.096 MHz clock enable pulse |
| en_2m | output | 1 | 2.048 MHz clock enable pulse |
| frame_n | output | 1 | Active-low frame strobe around the wrap |
| slip | output | 1 | One-cycle pulse on a re-phase of more than one count |
| los | output | 1 | Loss of sync: two frames without an edge |

## Verification
The two functions that can collide are the natural wrap that completes the loss-of-sync timeout and a sync re-phase. The bench provokes this by entering sync mode, letting one wrap pass, and then dropping ext_ref when frame_pos reads 2045, so that the re-phase lands in the cycle where 2047 would have become 0. It judges the outcome at the ports: frame_pos must read 3, slip must pulse, and los must never rise. Separate edges placed at offsets 0, +1 and +2 from the expected phase exercise the slip threshold.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2,
        ST_LOST   = 2'd3
    } sync_state_e;

    localparam int RATE_CODES = 3;

    // counts added per input tick for a given master-input rate code
    function automatic logic [2:0] step_of(input logic [1:0] rate);
        logic [2:0] s;
        unique case (rate)
            2'd1:    s = 3'd2;
            2'd2:    s = 3'd4;
            default: s = 3'd1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ftg_edge_detect.sv
module ftg_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    // pipe[0] is the first synchroniser stage; pipe[STAGES] holds the previous sample
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= 1'b1;
        else        pipe[0] <= din;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= 1'b1;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign fall = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/ftg_frame_counter.sv
module ftg_frame_counter
    import ftg_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int ALIGN   = 3,
    parameter int FP_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       rate,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             slip,
    output logic [2:0]       en,
    output logic             frame_n
);

    localparam logic [CNT_W-1:0] ALIGN_V = CNT_W'(ALIGN);
    localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(FP_HALF);
    localparam logic [CNT_W-1:0] WIN_V   = CNT_W'(2 * FP_HALF);

    logic [2:0]       step;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] adv_val;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] diff;
    logic [CNT_W-1:0] win_pos;
    logic             upd;
    logic             far;

    always_comb begin
        step    = step_of(rate);
        sum     = {1'b0, cnt} + (CNT_W+1)'(step);
        adv_val = tick ? sum[CNT_W-1:0] : cnt;
        wrap    = tick & sum[CNT_W] & ~load;
        nxt     = load ? ALIGN_V : adv_val;
        upd     = tick | load;
        diff    = ALIGN_V - adv_val;
        far     = !((diff == '0) || (diff == CNT_W'(1)) || (diff == '1));
        win_pos = nxt + HALF_V;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            slip    <= 1'b0;
            frame_n <= 1'b0;
        end else begin
            cnt  <= nxt;
            slip <= load & far;
            if (upd) frame_n <= ~(win_pos < WIN_V);
        end
    end

    // en[0] = 8.192 MHz, en[1] = 4.096 MHz, en[2] = 2.048 MHz
    for (genvar g = 0; g < 3; g++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) en[g] <= 1'b0;
            else        en[g] <= upd & (nxt[g:0] == '0);
        end
    end

    p_load_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == ALIGN_V);

    p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && rate == 2'd0 |=> cnt == $past(cnt) + CNT_W'(1));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load |=> $stable(cnt) && !slip);

    p_slip_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !slip);

endmodule

// File: rtl/ftg_sync_fsm.sv
module ftg_sync_fsm
    import ftg_pkg::*;
#(
    parameter int LOS_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic edge_seen,
    input  logic wrap,
    output logic load,
    output logic los
);

    localparam int WC_W = $clog2(LOS_FRAMES + 1);
    localparam logic [WC_W-1:0] WC_MAX  = WC_W'(LOS_FRAMES);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(LOS_FRAMES - 1);

    sync_state_e     state, nstate;
    logic [WC_W-1:0] wraps;
    logic            timeout;

    assign timeout = wrap & (wraps == WC_LAST) & ~edge_seen;

    always_comb begin
        nstate = state;
        if (!sync_mode) begin
            nstate = ST_FREE;
        end else begin
            unique case (state)
                ST_FREE:   nstate = edge_seen ? ST_LOCKED : ST_HUNT;
                ST_HUNT: begin
                    if (edge_seen)    nstate = ST_LOCKED;
                    else if (timeout) nstate = ST_LOST;
                end
                ST_LOCKED: begin
                    if (timeout) nstate = ST_LOST;
                end
                ST_LOST: begin
                    if (edge_seen) nstate = ST_LOCKED;
                end
                default:   nstate = ST_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      wraps <= '0;
        else if (!sync_mode || edge_seen) wraps <= '0;
        else if (wrap && wraps != WC_MAX) wraps <= wraps + WC_W'(1);
    end

    always_comb begin
        load = sync_mode & edge_seen;
        los  = (state == ST_LOST);
    end

    p_free_no_los_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |=> !los);

    p_edge_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode && edge_seen |=> !los);

    p_los_needs_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !los && !wrap |=> !los);

endmodule

// File: rtl/frame_timebase.sv
module frame_timebase
    import ftg_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int ALIGN       = 3,
    parameter int FP_HALF     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int LOS_FRAMES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_tick,
    input  logic [1:0]       in_rate,
    input  logic             sync_mode,
    input  logic             sync_sel,
    input  logic             bp_frame_n,
    input  logic             ext_ref,
    output logic [CNT_W-1:0] frame_pos,
    output logic             en_8m,
    output logic             en_4m,
    output logic             en_2m,
    output logic             frame_n,
    output logic             slip,
    output logic             los
);

    logic [1:0] src_in;
    logic [1:0] src_fall;
    logic       edge_seen;
    logic       load;
    logic       wrap;
    logic [2:0] en;

    assign src_in = {ext_ref, bp_frame_n};

    for (genvar s = 0; s < 2; s++) begin : g_src
        ftg_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (src_in[s]),
            .fall (src_fall[s])
        );
    end

    assign edge_seen = sync_sel ? src_fall[1] : src_fall[0];

    ftg_sync_fsm #(.LOS_FRAMES(LOS_FRAMES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_mode(sync_mode),
        .edge_seen(edge_seen),
        .wrap     (wrap),
        .load     (load),
        .los      (los)
    );

    ftg_frame_counter #(
        .CNT_W  (CNT_W),
        .ALIGN  (ALIGN),
        .FP_HALF(FP_HALF)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (in_tick),
        .rate   (in_rate),
        .load   (load),
        .cnt    (frame_pos),
        .wrap   (wrap),
        .slip   (slip),
        .en     (en),
        .frame_n(frame_n)
    );

    assign en_8m = en[0];
    assign en_4m = en[1];
    assign en_2m = en[2];

    p_en_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_2m |-> en_4m && en_8m);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !slip && !los && !en_8m);

endmodule

// File: tb/frame_timebase_bench.sv
`timescale 1ns/1ps
module frame_timebase_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_tick = 1'b1;
    logic [1:0]  in_rate = 2'd0;
    logic        sync_mode = 1'b0;
    logic        sync_sel = 1'b0;
    logic        bp_frame_n = 1'b1;
    logic        ext_ref = 1'b1;
    logic [10:0] frame_pos;
    logic        en_8m, en_4m, en_2m, frame_n, slip, los;

    int errors = 0;
    int checks = 0;
    int tdiv = 1;
    int tph = 0;
    bit done = 1'b0;

    localparam int LAT = 3;
    localparam int ALIGN = 3;

    always #2.5 clk = ~clk;

    frame_timebase u_frame_timebase (
        .clk(clk), .rst_n(rst_n), .in_tick(in_tick), .in_rate(in_rate),
        .sync_mode(sync_mode), .sync_sel(sync_sel), .bp_frame_n(bp_frame_n),
        .ext_ref(ext_ref), .frame_pos(frame_pos), .en_8m(en_8m), .en_4m(en_4m),
        .en_2m(en_2m), .frame_n(frame_n), .slip(slip), .los(los)
    );

    // input tick generator: one tick every tdiv master cycles
    always @(negedge clk) begin
        if (tdiv <= 1) begin
            in_tick <= 1'b1;
        end else begin
            tph = (tph + 1) % tdiv;
            in_tick <= (tph == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pos(input int v);
        do @(negedge clk); while (int'(frame_pos) != v);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cyc(3);
        chk("R1 pos", frame_pos, 0);
        chk("R1 frame_n", frame_n, 0);
        chk("R1 enables", {en_8m, en_4m, en_2m}, 0);
        chk("R1 slip/los", {slip, los}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_free_run;
        int bad = 0;
        int low = 0;
        for (int i = 1; i <= 16; i++) begin
            cyc(1);
            if (int'(frame_pos) != i || en_8m != (i % 2 == 0) ||
                en_4m != (i % 4 == 0) || en_2m != (i % 8 == 0)) bad++;
        end
        chk("R2/R3 unit advance and enables", bad, 0);
        wait_pos(2043);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            int c;
            cyc(1);
            c = (2044 + i) % 2048;
            if (int'(frame_pos) != c) bad++;
            if (frame_n != !(c >= 2046 || c <= 1)) bad++;
            if (!frame_n) low++;
        end
        chk("R2/R4 wrap and strobe window", bad, 0);
        chk("R4 strobe low cycles", low, 4);
    endtask

    task automatic t_ignore;
        int c;
        sync_mode = 1'b0;
        cyc(1);
        c = frame_pos;
        bp_frame_n = 1'b0;
        ext_ref = 1'b0;
        cyc(6);
        chk("R5 edges ignored in free run", frame_pos, (c + 6) % 2048);
        chk("R5 los low in free run", {los, slip}, 0);
        bp_frame_n = 1'b1;
        ext_ref = 1'b1;
        cyc(4);
    endtask

    task automatic t_sync_bp;
        sync_mode = 1'b1;
        sync_sel = 1'b0;
        wait_pos(100);
        ext_ref = 1'b0;
        cyc(4);
        chk("R7 unselected ext_ref ignored", frame_pos, 104);
        ext_ref = 1'b1;
        wait_pos(500);
        bp_frame_n = 1'b0;
        cyc(LAT - 1);
        chk("R6 no load before latency", frame_pos, 502);
        cyc(1);
        chk("R6 re-phase to alignment", frame_pos, ALIGN);
        chk("R8 slip on large jump", slip, 1);
        cyc(1);
        chk("R8 slip is one cycle", slip, 0);
        bp_frame_n = 1'b1;
        wait_pos(0);
        bp_frame_n = 1'b0;
        cyc(LAT);
        chk("R8 in-phase edge keeps count", frame_pos, ALIGN);
        chk("R8 in-phase edge no slip", slip, 0);
        bp_frame_n = 1'b1;
        wait_pos(1);
        bp_frame_n = 1'b0;
        cyc(LAT);
        chk("R8 one-count shift applied", frame_pos, ALIGN);
        chk("R8 one-count shift no slip", slip, 0);
        bp_frame_n = 1'b1;
        wait_pos(2);
        bp_frame_n = 1'b0;
        cyc(LAT);
        chk("R8 two-count shift applied", frame_pos, ALIGN);
        chk("R8 two-count shift slips", slip, 1);
        bp_frame_n = 1'b1;
    endtask

    task automatic t_sync_ext;
        sync_sel = 1'b1;
        wait_pos(1000);
        bp_frame_n = 1'b0;
        cyc(4);
        chk("R7 unselected backplane ignored", frame_pos, 1004);
        bp_frame_n = 1'b1;
        wait_pos(1500);
        ext_ref = 1'b0;
        cyc(LAT);
        chk("R7 ext_ref re-phases", frame_pos, ALIGN);
        chk("R8 ext_ref slip", slip, 1);
        ext_ref = 1'b1;
    endtask

    task automatic t_los;
        wait_pos(0);
        chk("R9 no los after one wrap", los, 0);
        wait_pos(2047);
        chk("R9 no los before second wrap", los, 0);
        cyc(1);
        chk("R9 los at second wrap", los, 1);
        chk("R9 free-running count continues", frame_pos, 0);
        wait_pos(10);
        ext_ref = 1'b0;
        cyc(LAT);
        chk("R9 edge clears los", los, 0);
        chk("R9 edge re-phases", frame_pos, ALIGN);
        ext_ref = 1'b1;
    endtask

    task automatic t_coincide;
        int seen = 0;
        sync_mode = 1'b0;
        cyc(2);
        sync_mode = 1'b1;
        wait_pos(0);
        wait_pos(2045);
        ext_ref = 1'b0;
        cyc(2);
        chk("R10 count before collision", frame_pos, 2047);
        if (los) seen++;
        cyc(1);
        chk("R10 re-phase wins over wrap", frame_pos, ALIGN);
        chk("R10 slip at collision", slip, 1);
        if (los) seen++;
        ext_ref = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (los) seen++;
        end
        chk("R10 los never raised", seen, 0);
        sync_mode = 1'b0;
    endtask

    task automatic t_rates;
        for (int r = 0; r < 4; r++) begin
            int n8 = 0, n4 = 0, n2 = 0, low = 0, bad = 0;
            int stp;
            stp = (r == 1) ? 2 : (r == 2) ? 4 : 1;
            sync_mode = 1'b0;
            in_rate = 2'(r);
            tdiv = stp;
            rst_n = 1'b0;
            cyc(3);
            rst_n = 1'b1;
            cyc(8);
            for (int i = 0; i < 4096; i++) begin
                cyc(1);
                if (en_8m) n8++;
                if (en_4m) n4++;
                if (en_2m) n2++;
                if (!frame_n) low++;
                if (int'(frame_pos) % stp != 0) bad++;
            end
            $display("rate code %0d", r);
            chk("R2 count on step grid", bad, 0);
            chk("R3 en_8m pulses per two frames", n8, (stp == 4) ? 1024 : 2048);
            chk("R3 en_4m pulses per two frames", n4, 1024);
            chk("R3 en_2m pulses per two frames", n2, 512);
            chk("R4 strobe low cycles per two frames", low, 8);
        end
        tdiv = 1;
        in_rate = 2'd0;
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_free_run();
        t_ignore();
        t_sync_bp();
        t_sync_ext();
        t_los();
        t_coincide();
        t_rates();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule